// File: doc/BRIEF.md
# Capture-Compare Timer Event Flags

This block pairs a free-running 16-bit up-counter with one 8-bit control and status register. The register holds sticky event flags for two capture inputs, two comparison registers and counter wrap-around, along with one interrupt enable for each event class. Software reads the register back, clears the flags it has handled by writing zeros, and sets the enables. One level-sensitive interrupt request reports every flag whose class is enabled.

The two capture inputs are asynchronous. Each one passes through a two-stage synchronizer, and a rising edge after the synchronizer counts as a valid edge. While capture/compare mode is selected, a valid edge sets that input's flag and copies the counter into a capture holding register. Two comparison values are supplied from outside the block, and a select input chooses which of them is active. Only a match on the active comparison value sets its flag.

Top module: `cctimer_flags`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the counter, the register readback, the capture holding value and the interrupt request are all 0.
- R2: The counter advances by one on every clock edge. After 16'hFFFF it wraps to 16'h0000.
- R3: The register bit layout is: bit 7 capture flag B, bit 6 capture flag A, bit 5 capture enable, bit 4 compare flag B, bit 3 compare flag A, bit 2 compare enable, bit 1 wrap flag, bit 0 wrap enable. A write loads all eight bits from the write data. Readback shows the register value.
- R4: In capture/compare mode (`ccmode`=1), a rising edge on `cap_a_in` sets bit 6 and a rising edge on `cap_b_in` sets bit 7. The flag appears on the third clock edge after the input rises. On that same edge `cap_val` takes the counter value from just before the edge.
- R5: With `ccmode`=0, capture edges set no flag and leave `cap_val` unchanged.
- R6: `cmp_sel`=0 makes `cmp_a` active and `cmp_sel`=1 makes `cmp_b` active. On the clock edge at which the counter equals the active value, the matching flag (bit 3 for A, bit 4 for B) sets, whatever the mode. A match on the inactive value sets nothing.
- R7: The wrap flag (bit 1) sets on the edge at which the counter goes from 16'hFFFF to 16'h0000.
- R8: Every flag stays at 1 after its event has passed, until a write loads it with 0.
- R9: If a hardware event and a write of 0 hit the same flag on the same edge, the flag ends at 1.
- R10: `irq` is 1 exactly when any of three conditions holds: (a capture flag is set and bit 5 is set), (a compare flag is set and bit 2 is set), or (bit 1 and bit 0 are both set).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ccmode | input | 1 | Selects capture/compare mode |
| cap_a_in | input | 1 | Asynchronous capture input A |
| cap_b_in | input | 1 | Asynchronous capture input B |
| cmp_a | input | 16 | Comparison value A |
| cmp_b | input | 16 | Comparison value B |
| cmp_sel | input | 1 | Active comparison value: 0 = A, 1 = B |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| ctl_rd | output | 8 | Register readback |
| cap_val | output | 16 | Counter value held at the last capture |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several properties on every cycle:
- the counter steps by exactly one;
- a flag never drops unless a write loads it;
- a compare flag or wrap flag rises only after its triggering condition or a write;
- a match on the active value always leaves its flag set, even under a same-cycle clear.

Only the bench scenarios show the following:
- the three-edge capture latency through the synchronizer, and the exact counter value latched;
- the capture inputs being ignored outside capture/compare mode;
- the gating of the interrupt request for each class;
- the real wrap from 16'hFFFF.

// File: rtl/cctimer_flags.sv
module cctimer_flags #(
  parameter int CW   = 16,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ccmode,
  input  logic          cap_a_in,
  input  logic          cap_b_in,
  input  logic [CW-1:0] cmp_a,
  input  logic [CW-1:0] cmp_b,
  input  logic          cmp_sel,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  output logic [7:0]    ctl_rd,
  output logic [CW-1:0] cap_val,
  output logic          irq
);
  logic [CW-1:0] cnt;
  logic [7:0]    ctl;
  logic [SYNC:0] sync_a, sync_b;

  wire hit_a   = ccmode && sync_a[SYNC-1] && !sync_a[SYNC];
  wire hit_b   = ccmode && sync_b[SYNC-1] && !sync_b[SYNC];
  wire match_a = !cmp_sel && (cnt == cmp_a);
  wire match_b =  cmp_sel && (cnt == cmp_b);
  wire wrap    = &cnt;

  wire [7:0] base = wr_en ? wr_data : ctl;
  wire [7:0] sets = {hit_b, hit_a, 1'b0, match_b, match_a, 1'b0, wrap, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      ctl     <= '0;
      cap_val <= '0;
      sync_a  <= '0;
      sync_b  <= '0;
    end else begin
      cnt    <= cnt + 1'b1;
      ctl    <= base | sets;
      sync_a <= {sync_a[SYNC-1:0], cap_a_in};
      sync_b <= {sync_b[SYNC-1:0], cap_b_in};
      if (hit_a || hit_b) cap_val <= cnt;
    end
  end

  assign ctl_rd = ctl;
  assign irq = ((ctl[7] | ctl[6]) & ctl[5]) |
               ((ctl[4] | ctl[3]) & ctl[2]) |
               (ctl[1] & ctl[0]);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cnt == CW'($past(cnt) + 1'b1));

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctl[3]) && !$past(wr_en)) |-> ctl[3]);

  // R6
  cmp_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl[3]) |-> ($past(wr_en && wr_data[3]) || $past(!cmp_sel && cnt == cmp_a)));

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_sel && cnt == cmp_a) |=> ctl[3]);

  // R5
  cap_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl[6]) |-> ($past(ccmode) || $past(wr_en && wr_data[6])));

  // R7
  wrap_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl[1]) |-> ($past(wr_en && wr_data[1]) || cnt == '0));
endmodule

// File: tb/tb_cctimer_flags.sv
module tb_cctimer_flags;
  logic clk = 0, rst_n = 0, ccmode = 1, cap_a_in = 0, cap_b_in = 0;
  logic [15:0] cmp_a = 16'h8000, cmp_b = 16'h8000;
  logic cmp_sel = 0, wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] ctl_rd;
  logic [15:0] cap_val;
  logic irq;
  logic [15:0] mcnt;
  logic [15:0] saved;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  cctimer_flags dut (.clk, .rst_n, .ccmode, .cap_a_in, .cap_b_in, .cmp_a, .cmp_b,
                     .cmp_sel, .wr_en, .wr_data, .ctl_rd, .cap_val, .irq);

  always @(posedge clk) if (!rst_n) mcnt <= 0; else mcnt <= mcnt + 1'b1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1; wr_data = d; step(1); wr_en = 0;
  endtask

  // {write data, expected irq}; readback must equal write data
  localparam logic [8:0] VEC [10] = '{
    {8'h02, 1'b0}, {8'h03, 1'b1}, {8'h18, 1'b0}, {8'h1C, 1'b1}, {8'hC0, 1'b0},
    {8'h60, 1'b1}, {8'hA0, 1'b1}, {8'h25, 1'b0}, {8'h0C, 1'b1}, {8'h00, 1'b0}};

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(3);
    check("R1 ctl", ctl_rd, 0); check("R1 irq", irq, 0); check("R1 cap", cap_val, 0);
    rst_n = 1; step(1);
    check("R1 first cycle", ctl_rd, 0);

    // R3 R10 vector table
    for (int v = 0; v < 10; v++) begin
      wr(VEC[v][8:1]);
      check("R3 readback", ctl_rd, VEC[v][8:1]);
      check("R10 irq gating", irq, VEC[v][0]);
    end

    // R4 capture A, latency and latched count (R2)
    cap_a_in = 1; step(2);
    check("R4 not before third edge", ctl_rd[6], 0);
    step(1);
    check("R4 flag A", ctl_rd, 8'h40);
    check("R4 R2 latched count", cap_val, mcnt - 16'd1);
    step(5);
    check("R8 capture flag sticky", ctl_rd, 8'h40);

    // R4 capture B
    wr(8'h00); cap_b_in = 1; step(3);
    check("R4 flag B", ctl_rd, 8'h80);
    check("R4 R2 latched count B", cap_val, mcnt - 16'd1);

    // R5 capture ignored outside mode
    cap_a_in = 0; cap_b_in = 0; step(4);
    ccmode = 0; wr(8'h20); saved = cap_val;
    cap_a_in = 1; cap_b_in = 1; step(6);
    check("R5 no flag", ctl_rd, 8'h20);
    check("R5 irq", irq, 0);
    check("R5 cap unchanged", cap_val, saved);

    // R6 compare A active, B inactive at same value, in mode 0
    wr(8'h04);
    cmp_sel = 0; cmp_a = mcnt + 16'd20; cmp_b = cmp_a;
    while (mcnt != cmp_a) step(1);
    check("R6 not early", ctl_rd[3], 0);
    step(1);
    check("R6 flag A only", ctl_rd, 8'h0C);
    check("R10 compare irq", irq, 1);
    step(3);
    check("R8 compare sticky", ctl_rd, 8'h0C);

    // R6 compare B active
    wr(8'h00); cmp_sel = 1; cmp_b = mcnt + 16'd15;
    while (mcnt != cmp_b) step(1);
    step(1);
    check("R6 flag B only", ctl_rd, 8'h10);
    check("R10 enable off", irq, 0);

    // R9 set beats same-cycle clear
    cmp_sel = 0; cmp_a = mcnt + 16'd10;
    while (mcnt != cmp_a) step(1);
    wr(8'h00);
    check("R9 set wins", ctl_rd, 8'h08);
    wr(8'h00);
    check("R8 write zero clears", ctl_rd, 8'h00);

    // R7 wrap
    cmp_a = 16'h4000; cmp_b = 16'h4000;
    while (mcnt != 16'hFFF0) step(1);
    wr(8'h01);
    while (mcnt != 16'hFFFF) step(1);
    check("R7 not before wrap", ctl_rd, 8'h01);
    step(1);
    check("R7 wrap flag", ctl_rd, 8'h03);
    check("R7 R2 wrapped", mcnt, 0);
    check("R10 wrap irq", irq, 1);

    // R1 reset mid-run
    rst_n = 0; step(2);
    check("R1 reset ctl", ctl_rd, 0); check("R1 reset cap", cap_val, 0); check("R1 reset irq", irq, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule